// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Sequencer

This block times a single programmed-I/O transfer on an IDE-style drive port. A transfer has three phases, each counted in clocks. First comes an address-settle phase, with the address-valid output high and no strobe. Next comes the strobe phase, where the read or write strobe is asserted. Last comes a release phase, where the strobe is off but the address stays valid. Each phase length is picked from an 8-bit timing byte through fixed, non-linear lookup codes.

Two timing bytes are supplied: one for the data register port and one for the command/control ports. Both drives on the channel share them. A start pulse, together with a direction flag and a port-class flag, launches a transfer. An optional ready input from the drive can hold the strobe phase open.

Start, busy and done are plain control pins. There is no valid/ready channel, because no data moves through the block. A start seen while busy is dropped rather than queued, so the caller waits for busy to fall or for done before issuing the next start.

Top module: `pio_cycle_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_valid`, `rd_strobe`, `wr_strobe`, `busy` and `done` are all low until a start is accepted.
- R2: The address-settle phase lasts (timing bits [7:6] + 1) clocks: code 0 gives 1, code 1 gives 2, code 2 gives 3 and code 3 gives 4.
- R3: The release phase length comes from timing bits [5:3]. Codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks.
- R4: The strobe phase length comes from timing bits [2:0]. Codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks, provided no ready stretch applies.
- R5: With `cmd_port` low at start, `data_timing` sets the lengths. With `cmd_port` high, `cmd_timing` sets them.
- R6: When `write` was low at start, only `rd_strobe` pulses. When it was high, only `wr_strobe` pulses. The two strobes are never high together. `addr_valid` stays high through all three phases and any strobe implies `addr_valid`.
- R7: If `iordy_en` is high and `iordy` is low at the last strobe clock, the strobe phase continues. It ends after the first clock on which `iordy` is sampled high.
- R8: When `iordy_en` is low, the level of `iordy` has no effect on any phase length.
- R9: The timing byte, the port-class flag and the direction are captured when start is accepted. Changes to those inputs during a transfer have no effect on it.
- R10: `busy` is high from the clock after start is accepted through the last release clock. A start seen while `busy` is high is ignored and launches no later transfer.
- R11: `done` is high for exactly one clock, the last release clock. A start present on the next clock is accepted, so the next transfer begins one idle clock after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a transfer, taken only when idle |
| write | input | 1 | 1 = write transfer, 0 = read transfer |
| cmd_port | input | 1 | 1 = command/control port timing, 0 = data port timing |
| data_timing | input | 8 | Timing byte for data port transfers |
| cmd_timing | input | 8 | Timing byte for command/control transfers |
| iordy_en | input | 1 | Honour the drive ready input |
| iordy | input | 1 | Drive ready, low requests more strobe time |
| addr_valid | output | 1 | Address is driven to the drive |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse on the final release clock |

## Verification
The main function is tried with a set of timing bytes chosen so that every code of all three fields appears at least once. These include the slow, mid-speed and fast data settings and the usual command/control setting, each run on both port classes and in both directions. The bench measures the three phase lengths separately, so a wrong entry in any single lookup is caught, and so is a swapped field or a mix-up between the two timing bytes. Separate runs hold the ready input low with the ready feature enabled and then disabled, which tells a correct stretch apart from a stretch that happens regardless of the enable. Other runs change the inputs and pulse start mid-transfer, which tells capture-at-start apart from live reading. A run with start held high checks that exactly one idle clock separates back-to-back transfers.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int LEN_W = 5;

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    len_t setup;
    len_t active;
    len_t hold;
  } lens_t;

  function automatic len_t setup_clocks(input logic [1:0] code);
    return len_t'(code) + len_t'(1);
  endfunction

  function automatic len_t hold_clocks(input logic [2:0] code);
    len_t r;
    case (code)
      3'd6:    r = len_t'(8);
      3'd7:    r = len_t'(12);
      default: r = len_t'(code) + len_t'(1);
    endcase
    return r;
  endfunction

  function automatic len_t active_clocks(input logic [2:0] code);
    len_t r;
    case (code)
      3'd5:    r = len_t'(8);
      3'd6:    r = len_t'(12);
      3'd7:    r = len_t'(16);
      default: r = len_t'(code) + len_t'(2);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timing_pkg::*;
#(
  parameter int TW         = 8,
  parameter int SETUP_LSB  = 6,
  parameter int HOLD_LSB   = 3,
  parameter int ACTIVE_LSB = 0
) (
  input  logic [TW-1:0] tbyte,
  output lens_t         lens
);

  always_comb begin
    lens.setup  = setup_clocks(tbyte[SETUP_LSB +: 2]);
    lens.hold   = hold_clocks(tbyte[HOLD_LSB +: 3]);
    lens.active = active_clocks(tbyte[ACTIVE_LSB +: 3]);
  end

endmodule

// File: rtl/pio_cycle_capture.sv
module pio_cycle_capture
  import pio_timing_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  lens_t lens_in,
  input  logic  write_in,
  output lens_t lens_q,
  output logic  write_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lens_q  <= '0;
      write_q <= 1'b0;
    end else if (capture) begin
      lens_q  <= lens_in;
      write_q <= write_in;
    end
  end

endmodule

// File: rtl/pio_phase_counter.sv
module pio_phase_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - ONE;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import pio_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   cnt_zero,
  input  logic   stretch,
  output phase_e phase,
  output logic   accept,
  output logic   load,
  output phase_e load_sel,
  output logic   dec
);

  phase_e next;

  always_comb begin
    next     = phase;
    accept   = 1'b0;
    load     = 1'b0;
    load_sel = PH_IDLE;
    dec      = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          accept   = 1'b1;
          next     = PH_SETUP;
          load     = 1'b1;
          load_sel = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          next     = PH_ACTIVE;
          load     = 1'b1;
          load_sel = PH_ACTIVE;
        end else begin
          dec = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cnt_zero) begin
          if (!stretch) begin
            next     = PH_HOLD;
            load     = 1'b1;
            load_sel = PH_HOLD;
          end
        end else begin
          dec = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) next = PH_IDLE;
        else          dec  = 1'b1;
      end
      default: next = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= next;
  end

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timing_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          write,
  input  logic          cmd_port,
  input  logic [TW-1:0] data_timing,
  input  logic [TW-1:0] cmd_timing,
  input  logic          iordy_en,
  input  logic          iordy,
  output logic          addr_valid,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          busy,
  output logic          done
);

  localparam int NPORT = 2;

  logic [TW-1:0] tbytes [NPORT];
  lens_t         port_lens [NPORT];
  lens_t         live_lens;
  lens_t         lens_q;
  logic          write_q;
  phase_e        phase;
  phase_e        load_sel;
  logic          accept, load, dec, cnt_zero, stretch;
  len_t          load_len;
  len_t          load_val;

  assign tbytes[0] = data_timing;
  assign tbytes[1] = cmd_timing;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_timing_decode #(.TW(TW)) u_dec (
      .tbyte (tbytes[p]),
      .lens  (port_lens[p])
    );
  end

  assign live_lens = cmd_port ? port_lens[1] : port_lens[0];

  pio_cycle_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .lens_in  (live_lens),
    .write_in (write),
    .lens_q   (lens_q),
    .write_q  (write_q)
  );

  assign stretch = iordy_en && !iordy;

  pio_cycle_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt_zero (cnt_zero),
    .stretch  (stretch),
    .phase    (phase),
    .accept   (accept),
    .load     (load),
    .load_sel (load_sel),
    .dec      (dec)
  );

  always_comb begin
    unique case (load_sel)
      PH_SETUP:  load_len = live_lens.setup;
      PH_ACTIVE: load_len = lens_q.active;
      PH_HOLD:   load_len = lens_q.hold;
      default:   load_len = len_t'(1);
    endcase
  end

  assign load_val = load_len - len_t'(1);

  pio_phase_counter #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .zero     (cnt_zero)
  );

  assign busy       = (phase != PH_IDLE);
  assign addr_valid = (phase != PH_IDLE);
  assign rd_strobe  = (phase == PH_ACTIVE) && !write_q;
  assign wr_strobe  = (phase == PH_ACTIVE) &&  write_q;
  assign done       = (phase == PH_HOLD) && cnt_zero;

endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic iordy_en,
  input logic iordy,
  input logic addr_valid,
  input logic rd_strobe,
  input logic wr_strobe,
  input logic busy,
  input logic done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_strobe && wr_strobe)); // R6
  AST_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe || wr_strobe) |-> addr_valid); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R11
  AST_DONE_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R10
  AST_RD_READY:    assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_strobe) |-> $past(!iordy_en || iordy)); // R7
  AST_WR_READY:    assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_strobe) |-> $past(!iordy_en || iordy)); // R7

endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iordy_en   (iordy_en),
  .iordy      (iordy),
  .addr_valid (addr_valid),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_pio_cycle_timer.sv
`timescale 1ns/1ps
module tb_pio_cycle_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       write = 1'b0;
  logic       cmd_port = 1'b0;
  logic [7:0] data_timing = 8'hF5;
  logic [7:0] cmd_timing = 8'hDE;
  logic       iordy_en = 1'b0;
  logic       iordy = 1'b1;
  logic       addr_valid, rd_strobe, wr_strobe, busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pio_cycle_timer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .cmd_port(cmd_port),
    .data_timing(data_timing), .cmd_timing(cmd_timing), .iordy_en(iordy_en),
    .iordy(iordy), .addr_valid(addr_valid), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .busy(busy), .done(done)
  );

  // {write, cmd_port, data byte, cmd byte, settle, strobe, release}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hF5, 8'hDE, 5'd4, 5'd8,  5'd8},
    {1'b1, 1'b1, 8'hF5, 8'hDE, 5'd4, 5'd12, 5'd4},
    {1'b0, 1'b0, 8'h09, 8'hDE, 5'd1, 5'd3,  5'd2},
    {1'b1, 1'b0, 8'h00, 8'hDE, 5'd1, 5'd2,  5'd1},
    {1'b0, 1'b1, 8'h00, 8'h3F, 5'd1, 5'd16, 5'd12},
    {1'b1, 1'b0, 8'hC0, 8'h3F, 5'd4, 5'd2,  5'd1},
    {1'b0, 1'b0, 8'h52, 8'h00, 5'd2, 5'd4,  5'd3},
    {1'b1, 1'b1, 8'h52, 8'h9B, 5'd3, 5'd5,  5'd4},
    {1'b0, 1'b0, 8'h24, 8'hFF, 5'd1, 5'd6,  5'd5},
    {1'b0, 1'b0, 8'h28, 8'hFF, 5'd1, 5'd2,  5'd6}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // rel_at: strobe-clock count at which iordy is raised again (0 = at end)
  // mut: alter inputs and pulse start during the transfer
  task automatic run_cycle(input bit wr, input bit cp, input logic [7:0] db, input logic [7:0] cb,
                           input bit en, input bit hold_low, input int rel_at, input bit mut,
                           input int es, input int ea, input int eh, input string tag);
    int n_set = 0, n_act = 0, n_hold = 0, n_done = 0, bad_dir = 0, k = 0;
    bit seen_act = 0, got_done = 0, early_idle = 0;
    @(negedge clk);
    write = wr; cmd_port = cp; data_timing = db; cmd_timing = cb;
    iordy_en = en; iordy = hold_low ? 1'b0 : 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!got_done && k < 200) begin
      if (!busy) begin early_idle = 1; break; end
      if (rd_strobe || wr_strobe) begin
        n_act++; seen_act = 1;
        if (wr ? !(wr_strobe && !rd_strobe) : !(rd_strobe && !wr_strobe)) bad_dir++;
        if (!addr_valid) bad_dir++;
      end else if (addr_valid) begin
        if (seen_act) n_hold++; else n_set++;
      end
      if (done) begin n_done++; got_done = 1; end
      if (hold_low && rel_at != 0 && n_act == rel_at) iordy = 1'b1;
      if (mut && k == 0) begin
        data_timing = 8'h00; cmd_timing = 8'h00; cmd_port = ~cp; write = ~wr; start = 1'b1;
      end
      if (mut && k == 1) start = 1'b0;
      k++;
      @(negedge clk);
    end
    iordy = 1'b1;
    check(!early_idle, {tag, " R10 busy held until done"}, early_idle, 0);
    check(n_set == es, {tag, " R2 settle clocks"}, n_set, es);
    check(n_act == ea, {tag, " R4 strobe clocks"}, n_act, ea);
    check(n_hold == eh, {tag, " R3 release clocks"}, n_hold, eh);
    check(bad_dir == 0, {tag, " R6 strobe direction"}, bad_dir, 0);
    check(n_done == 1, {tag, " R11 done pulses"}, n_done, 1);
    // clock after done: idle, and no transfer launched by a start seen while busy
    check(!busy && !addr_valid && !done, {tag, " R10 idle after done"}, busy, 0);
    repeat (2) @(negedge clk);
    check(!busy, {tag, " R10 no late transfer"}, busy, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check({addr_valid, rd_strobe, wr_strobe, busy, done} == 5'b0, "R1 outputs in reset",
          {addr_valid, rd_strobe, wr_strobe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({addr_valid, rd_strobe, wr_strobe, busy, done} == 5'b0, "R1 outputs after reset",
          {addr_valid, rd_strobe, wr_strobe, busy, done}, 0);

    // table walk: every field code, both port classes (R5), both directions (R6)
    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i][32], VEC[i][31], VEC[i][30:23], VEC[i][22:15], 1'b0, 1'b0, 0, 1'b0,
                int'(VEC[i][14:10]), int'(VEC[i][9:5]), int'(VEC[i][4:0]), "R5 table");
    end

    // R7: ready enabled and low, released after 3 extra strobe clocks (0xF5: strobe 8)
    run_cycle(1'b0, 1'b0, 8'hF5, 8'hDE, 1'b1, 1'b1, 11, 1'b0, 4, 11, 8, "R7 stretch");
    // R7: ready low but already high when strobe count would end -> no stretch
    run_cycle(1'b1, 1'b0, 8'h09, 8'hDE, 1'b1, 1'b1, 3, 1'b0, 1, 3, 2, "R7 release on time");
    // R8: ready disabled, held low throughout
    run_cycle(1'b1, 1'b1, 8'hF5, 8'h52, 1'b0, 1'b1, 0, 1'b0, 2, 4, 3, "R8 ready ignored");
    // R9: inputs changed and start pulsed mid-transfer
    run_cycle(1'b0, 1'b0, 8'hF5, 8'hDE, 1'b0, 1'b0, 0, 1'b1, 4, 8, 8, "R9 captured");
    run_cycle(1'b1, 1'b1, 8'h00, 8'h3F, 1'b0, 1'b0, 0, 1'b1, 1, 16, 12, "R9 captured cmd");

    // R11: start held high, 0x00 timing gives 4 busy clocks then one idle clock
    begin
      int dn = 0;
      logic [9:0] bseq;
      @(negedge clk);
      data_timing = 8'h00; cmd_port = 1'b0; write = 1'b0; start = 1'b1;
      for (int s = 0; s < 10; s++) begin
        @(negedge clk);
        bseq[s] = busy;
        if (done) dn++;
      end
      start = 1'b0;
      check(bseq == 10'b0111101111, "R11 back-to-back busy pattern", int'(bseq), 10'b0111101111);
      check(dn == 2, "R11 done count back-to-back", dn, 2);
      repeat (6) @(negedge clk);
      check(!busy, "R11 idle after start drops", busy, 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule